// File: doc/BRIEF.md
# Aligned Circular Pointer Update Unit

This unit generates operand addresses from a bank of eight address pointers and writes each pointer back after use. An operation selects one pointer and one of four modifications: step forward by one, step back by one, add the step register, or subtract the step register. The address presented for the access is the pointer value before the modification, so the unit behaves as a post-modify addressing stage.

When circular mode is requested and the length register is nonzero, the pointer moves inside a buffer of N words. Let b be the number of bits needed to write N in binary. The buffer base is the pointer with its b low bits cleared, and the last word of the buffer is base + N − 1. Stepping past either end continues at the opposite end. Any number of pointers may sit in different buffers that share the single length register. With circular mode off, or with a length of zero, the pointer is updated with plain 16-bit wrap-around arithmetic.

Software loads the length register, the step register and the pointers through three write ports. The step register is two's complement, so a negative value reverses the direction of the add-step and subtract-step operations. Each step must not exceed N in magnitude.

Top module: `circ_ptr_unit`

## Requirements
- R1: While reset is asserted `addrValid` is 0. Reset clears every pointer, the length register and the step register to zero, so the first operation on any pointer after reset presents address 0.
- R2: An operation accepted on a rising edge produces `addrValid` = 1 on the next cycle, with `addrOut` equal to the selected pointer's value before modification. In a cycle with no operation, `addrValid` is 0 on the following cycle.
- R3: In circular mode, the forward modifications (`opCode` 0 = +1, 2 = +step) that carry the offset beyond N − 1 continue from the base, with the excess carried over.
- R4: In circular mode, the backward modifications (`opCode` 1 = −1, 3 = −step) that carry the offset below zero continue from base + N − 1, with the shortfall carried over.
- R5: The step register is two's complement. A negative step makes +step move backward and −step move forward, with wrapping applied as in R3 and R4.
- R6: The buffer base is the pointer with its b low bits zeroed, where b is the bit length of N. This also holds when N is not a power of two. For example, with N = 30 the base is a multiple of 32 and the highest address used is base + 29.
- R7: Pointers in different buffers that share the same length register wrap independently. Updating one pointer leaves every other pointer unchanged.
- R8: With `circEn` = 0, the pointer is updated as (pointer ± step) modulo 2^16, and no buffer limit applies.
- R9: With the length register equal to 0, the update is linear as in R8 even when `circEn` = 1.
- R10: When a pointer write and an operation target the same pointer in one cycle, the written value is kept. The operation still presents the old value. Writes to the length and step registers take effect for operations in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation request this cycle |
| opSel | input | 3 | Pointer selected by the operation |
| opCode | input | 2 | Modification: 0 +1, 1 −1, 2 +step, 3 −step |
| circEn | input | 1 | 1 = circular update, 0 = linear update |
| sizeWe | input | 1 | Write enable for the buffer length register |
| sizeWdata | input | 16 | New buffer length N |
| indexWe | input | 1 | Write enable for the step register |
| indexWdata | input | 16 | New step value (two's complement) |
| ptrWe | input | 1 | Write enable for a pointer |
| ptrWsel | input | 3 | Pointer written by the write port |
| ptrWdata | input | 16 | New pointer value |
| addrValid | output | 1 | `addrOut` carries an operation's address |
| addrOut | output | 16 | Pointer value before modification |

## Verification
Every pointer state is visible only through the address that the next operation on that pointer presents, one cycle after that operation is accepted. A wrong wrap, base or step therefore shows at the ports no earlier than the second operation on the affected pointer. The bench issues back-to-back operations on the same pointer so that an error appears within two cycles. It also interleaves pointers so that corruption of a pointer that was not selected appears when that pointer is next used.

// File: rtl/circ_pkg.sv
package circ_pkg;

  typedef enum logic [1:0] {
    OP_INC    = 2'd0,
    OP_DEC    = 2'd1,
    OP_ADDIDX = 2'd2,
    OP_SUBIDX = 2'd3
  } opCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic updPtr;    // write the modified value back to the selected pointer
    logic useIndex;  // step magnitude comes from the step register
    logic negStep;   // negate the step
    logic wrap;      // circular update requested
    logic emitAddr;  // present the pre-modify address next cycle
    logic loadPtr;
    logic loadSize;
    logic loadIndex;
  } strobes_t;

endpackage

// File: rtl/circ_ctrl.sv
module circ_ctrl
  import circ_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             opValid,
  input  logic [SEL_W-1:0] opSel,
  input  logic [1:0]       opCode,
  input  logic             circEn,
  input  logic             ptrWe,
  input  logic [SEL_W-1:0] ptrWsel,
  input  logic             sizeWe,
  input  logic             indexWe,
  output strobes_t         stb
);

  opCode_e code;
  logic    collide;

  always_comb begin
    code    = opCode_e'(opCode);
    collide = ptrWe && (ptrWsel == opSel);

    stb           = '0;
    stb.emitAddr  = opValid;
    stb.updPtr    = opValid && !collide;
    stb.wrap      = circEn;
    stb.loadPtr   = ptrWe;
    stb.loadSize  = sizeWe;
    stb.loadIndex = indexWe;

    unique case (code)
      OP_INC:    begin stb.useIndex = 1'b0; stb.negStep = 1'b0; end
      OP_DEC:    begin stb.useIndex = 1'b0; stb.negStep = 1'b1; end
      OP_ADDIDX: begin stb.useIndex = 1'b1; stb.negStep = 1'b0; end
      OP_SUBIDX: begin stb.useIndex = 1'b1; stb.negStep = 1'b1; end
      default:   begin stb.useIndex = 1'b0; stb.negStep = 1'b0; end
    endcase
  end

endmodule

// File: rtl/circ_wrap.sv
module circ_wrap #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic [ADDR_W-1:0] step,     // two's complement
  input  logic [ADDR_W-1:0] bufLen,
  input  logic              wrapEn,
  output logic [ADDR_W-1:0] ptrNext
);

  localparam int EXT_W = ADDR_W + 2;

  logic [ADDR_W-1:0]       lowMask;
  logic [ADDR_W-1:0]       base;
  logic [ADDR_W-1:0]       offset;
  logic signed [EXT_W-1:0] sum;
  logic signed [EXT_W-1:0] lenExt;
  logic signed [EXT_W-1:0] adj;
  logic                    circActive;

  // every bit at or below the top set bit of the length
  always_comb begin
    lowMask[ADDR_W-1] = bufLen[ADDR_W-1];
    for (int i = ADDR_W - 2; i >= 0; i--) begin
      lowMask[i] = lowMask[i+1] | bufLen[i];
    end
  end

  always_comb begin
    circActive = wrapEn && (bufLen != '0);
    base       = ptrIn & ~lowMask;
    offset     = ptrIn & lowMask;
    lenExt     = $signed({2'b00, bufLen});
    sum        = $signed({2'b00, offset}) + $signed({{2{step[ADDR_W-1]}}, step});
    if (sum < 0)
      adj = sum + lenExt;
    else if (sum >= lenExt)
      adj = sum - lenExt;
    else
      adj = sum;

    if (circActive)
      ptrNext = base + adj[ADDR_W-1:0];
    else
      ptrNext = ptrIn + step;
  end

endmodule

// File: rtl/circ_dp.sv
module circ_dp
  import circ_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_PTR = 8,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [SEL_W-1:0]  opSel,
  input  logic [SEL_W-1:0]  ptrWsel,
  input  logic [ADDR_W-1:0] ptrWdata,
  input  logic [ADDR_W-1:0] sizeWdata,
  input  logic [ADDR_W-1:0] indexWdata,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut
);

  logic [ADDR_W-1:0] ptrBank [NUM_PTR];
  logic [ADDR_W-1:0] lenReg;
  logic [ADDR_W-1:0] stepReg;
  logic [ADDR_W-1:0] curPtr;
  logic [ADDR_W-1:0] stepMag;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] nextPtr;

  always_comb begin
    curPtr  = ptrBank[opSel];
    stepMag = stb.useIndex ? stepReg : ADDR_W'(1);
    stepVal = stb.negStep ? (~stepMag + ADDR_W'(1)) : stepMag;
  end

  circ_wrap #(.ADDR_W(ADDR_W)) u_wrap (
    .ptrIn  (curPtr),
    .step   (stepVal),
    .bufLen (lenReg),
    .wrapEn (stb.wrap),
    .ptrNext(nextPtr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenReg  <= '0;
      stepReg <= '0;
    end else begin
      if (stb.loadSize)  lenReg  <= sizeWdata;
      if (stb.loadIndex) stepReg <= indexWdata;
    end
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ptrBank[g] <= '0;
      else if (stb.loadPtr && (ptrWsel == SEL_W'(g)))
        ptrBank[g] <= ptrWdata;
      else if (stb.updPtr && (opSel == SEL_W'(g)))
        ptrBank[g] <= nextPtr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrValid <= 1'b0;
      addrOut   <= '0;
    end else begin
      addrValid <= stb.emitAddr;
      if (stb.emitAddr) addrOut <= curPtr;
    end
  end

endmodule

// File: rtl/circ_ptr_unit.sv
module circ_ptr_unit
  import circ_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_PTR = 8,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [SEL_W-1:0]  opSel,
  input  logic [1:0]        opCode,
  input  logic              circEn,
  input  logic              sizeWe,
  input  logic [ADDR_W-1:0] sizeWdata,
  input  logic              indexWe,
  input  logic [ADDR_W-1:0] indexWdata,
  input  logic              ptrWe,
  input  logic [SEL_W-1:0]  ptrWsel,
  input  logic [ADDR_W-1:0] ptrWdata,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut
);

  strobes_t stb;

  circ_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .opValid(opValid),
    .opSel  (opSel),
    .opCode (opCode),
    .circEn (circEn),
    .ptrWe  (ptrWe),
    .ptrWsel(ptrWsel),
    .sizeWe (sizeWe),
    .indexWe(indexWe),
    .stb    (stb)
  );

  circ_dp #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .opSel     (opSel),
    .ptrWsel   (ptrWsel),
    .ptrWdata  (ptrWdata),
    .sizeWdata (sizeWdata),
    .indexWdata(indexWdata),
    .addrValid (addrValid),
    .addrOut   (addrOut)
  );

endmodule

// File: rtl/circ_ptr_unit_chk.sv
module circ_ptr_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              opValid,
  input logic [SEL_W-1:0]  opSel,
  input logic [1:0]        opCode,
  input logic              circEn,
  input logic              sizeWe,
  input logic [ADDR_W-1:0] sizeWdata,
  input logic              indexWe,
  input logic              ptrWe,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addrOut
);

  logic [ADDR_W-1:0] lenShadow;
  logic [ADDR_W-1:0] lenMask;
  logic [SEL_W-1:0]  lastSel;
  logic              lastCirc;
  logic              lastLinInc;
  logic              circChain;
  logic              linChain;
  logic              outInBuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenShadow  <= '0;
      lastSel    <= '0;
      lastCirc   <= 1'b0;
      lastLinInc <= 1'b0;
    end else begin
      if (sizeWe) lenShadow <= sizeWdata;
      lastSel    <= opSel;
      lastCirc   <= opValid && circEn && !ptrWe && !sizeWe && !indexWe;
      lastLinInc <= opValid && !circEn && (opCode == 2'd0) && !ptrWe;
    end
  end

  always_comb begin
    lenMask[ADDR_W-1] = lenShadow[ADDR_W-1];
    for (int i = ADDR_W - 2; i >= 0; i--) lenMask[i] = lenMask[i+1] | lenShadow[i];
    outInBuf  = addrValid && ((addrOut & lenMask) < lenShadow);
    circChain = opValid && circEn && !ptrWe && !sizeWe && !indexWe && lastCirc &&
                (opSel == lastSel) && (lenShadow != '0) && outInBuf;
    linChain  = opValid && !circEn && (opCode == 2'd0) && !ptrWe && lastLinInc &&
                (opSel == lastSel) && addrValid;
  end

  // R1: quiet output while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_n |=> !addrValid);

  // R2: one address per accepted operation, one cycle later
  p_valid_follows_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    opValid |=> addrValid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> !addrValid);

  // R6: consecutive circular uses of one pointer stay inside one buffer
  p_stays_in_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    circChain |=> ((addrOut & ~lenMask) == ($past(addrOut) & ~lenMask)) &&
                  ((addrOut & lenMask) < lenShadow));

  // R8: linear increment advances by exactly one modulo 2^ADDR_W
  p_linear_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    linChain |=> addrOut == $past(addrOut) + ADDR_W'(1));

endmodule

bind circ_ptr_unit circ_ptr_unit_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opValid  (opValid),
  .opSel    (opSel),
  .opCode   (opCode),
  .circEn   (circEn),
  .sizeWe   (sizeWe),
  .sizeWdata(sizeWdata),
  .indexWe  (indexWe),
  .ptrWe    (ptrWe),
  .addrValid(addrValid),
  .addrOut  (addrOut)
);

// File: tb/sim_circ_ptr_unit.sv
`timescale 1ns/1ps
module sim_circ_ptr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  opCode = '0;
  logic        circEn = 1'b0;
  logic        sizeWe = 1'b0;
  logic [15:0] sizeWdata = '0;
  logic        indexWe = 1'b0;
  logic [15:0] indexWdata = '0;
  logic        ptrWe = 1'b0;
  logic [2:0]  ptrWsel = '0;
  logic [15:0] ptrWdata = '0;
  logic        addrValid;
  logic [15:0] addrOut;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  int unsigned mPtr [8];
  int unsigned mLen = 0;
  int unsigned mIdx = 0;

  logic [15:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;  // 50 MHz

  circ_ptr_unit u0 (.*);

  function automatic int unsigned nextRef(int unsigned p, int s, bit circ);
    int unsigned b, mask, base, off;
    int t;
    if (circ && mLen != 0) begin
      b = 0;
      while ((mLen >> b) != 0) b++;
      mask = (1 << b) - 1;
      base = p & ~mask;
      off  = p & mask;
      t = int'(off) + s;
      t = ((t % int'(mLen)) + int'(mLen)) % int'(mLen);
      return base + t;
    end
    return (p + s) & 16'hFFFF;
  endfunction

  task automatic doOp(input int sel, input int code, input bit circ, input string tag,
                      input bit wr = 0, input int wsel = 0, input int wdata = 0);
    int s;
    int sIdx;
    @(negedge clk);
    sIdx = (mIdx >= 32768) ? int'(mIdx) - 65536 : int'(mIdx);
    case (code)
      0: s = 1;
      1: s = -1;
      2: s = sIdx;
      default: s = -sIdx;
    endcase
    expQ.push_back(16'(mPtr[sel]));
    tagQ.push_back(tag);
    mPtr[sel] = nextRef(mPtr[sel], s, circ);
    if (wr) mPtr[wsel] = wdata & 16'hFFFF;
    opValid = 1; opSel = 3'(sel); opCode = 2'(code); circEn = circ;
    ptrWe = wr; ptrWsel = 3'(wsel); ptrWdata = 16'(wdata);
    @(negedge clk);
    opValid = 0; ptrWe = 0;
  endtask

  task automatic setPtr(input int sel, input int val);
    @(negedge clk);
    ptrWe = 1; ptrWsel = 3'(sel); ptrWdata = 16'(val);
    mPtr[sel] = val & 16'hFFFF;
    @(negedge clk);
    ptrWe = 0;
  endtask

  task automatic setLen(input int val);
    @(negedge clk);
    sizeWe = 1; sizeWdata = 16'(val); mLen = val;
    @(negedge clk);
    sizeWe = 0;
  endtask

  task automatic setIdx(input int val);
    @(negedge clk);
    indexWe = 1; indexWdata = 16'(val); mIdx = val & 16'hFFFF;
    @(negedge clk);
    indexWe = 0;
  endtask

  // monitor: pops one expected address per valid output
  always @(negedge clk) begin
    if (rst_n && addrValid) begin
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R2 unexpected addrValid, actual addr %h expected none", addrOut);
      end else begin
        logic [15:0] e;
        string tg;
        e = expQ.pop_front();
        tg = tagQ.pop_front();
        if (addrOut !== e) begin
          miscompares++;
          $display("FAIL %s addrOut actual %h expected %h", tg, addrOut, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mPtr[i] = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (addrValid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 addrValid in reset actual %b expected 0", addrValid);
    end
    rst_n = 1;

    // R1: pointer cleared by reset
    doOp(3, 0, 0, "R1");
    doOp(3, 0, 0, "R1");

    // R3: forward wrap with N = 5 (base multiple of 8)
    setLen(5);
    setPtr(1, 16'h0040);
    for (int k = 0; k < 6; k++) doOp(1, 0, 1, "R3");
    // R4: backward wrap from base
    doOp(1, 1, 1, "R4");
    doOp(1, 1, 1, "R4");
    doOp(1, 1, 1, "R4");

    // R3/R4 with step register = 2
    setIdx(2);
    doOp(1, 2, 1, "R3");
    doOp(1, 2, 1, "R3");
    doOp(1, 2, 1, "R3");
    doOp(1, 3, 1, "R4");
    doOp(1, 3, 1, "R4");

    // R5: negative step reverses direction
    setIdx(-2);
    doOp(1, 2, 1, "R5");
    doOp(1, 2, 1, "R5");
    doOp(1, 3, 1, "R5");
    doOp(1, 3, 1, "R5");

    // R6: N = 30, base multiple of 32, top word base + 29
    setLen(30);
    setIdx(3);
    setPtr(4, 16'h0A1C);
    doOp(4, 2, 1, "R6");
    doOp(4, 2, 1, "R6");
    doOp(4, 1, 1, "R6");
    doOp(4, 1, 1, "R6");
    doOp(4, 0, 1, "R6");

    // R7: two pointers sharing the length register, interleaved
    setPtr(5, 16'h0C00);
    setPtr(6, 16'h0D1D);
    doOp(5, 1, 1, "R7");
    doOp(6, 0, 1, "R7");
    doOp(5, 1, 1, "R7");
    doOp(6, 0, 1, "R7");
    doOp(4, 0, 1, "R7");
    doOp(5, 2, 1, "R7");
    doOp(6, 3, 1, "R7");

    // R8: linear mode wraps only at 2^16
    setPtr(7, 16'hFFFE);
    doOp(7, 0, 0, "R8");
    doOp(7, 0, 0, "R8");
    doOp(7, 0, 0, "R8");
    doOp(7, 3, 0, "R8");
    doOp(7, 2, 0, "R8");

    // R9: length zero forces linear update even in circular mode
    setLen(0);
    setPtr(2, 16'h003F);
    doOp(2, 0, 1, "R9");
    doOp(2, 0, 1, "R9");
    doOp(2, 2, 1, "R9");

    // R10: pointer write wins over update of the same pointer
    setPtr(0, 16'h0100);
    doOp(0, 0, 0, "R10", 1, 0, 16'h0200);
    doOp(0, 0, 0, "R10");
    // R10: write to another pointer does not block the update
    doOp(0, 0, 0, "R10", 1, 3, 16'h0333);
    doOp(0, 0, 0, "R10");
    doOp(3, 0, 0, "R10");
    // R10: length write applies to later operations
    setLen(4);
    setPtr(6, 16'h0043);
    doOp(6, 0, 1, "R10");
    doOp(6, 0, 1, "R10");

    repeat (3) @(negedge clk);
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R2 missing addresses, actual %0d pending expected 0", expQ.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule